// File: doc/BRIEF.md
# Channel Status Double Buffer

This block keeps the channel-status bits of a two-channel serial audio transmitter in two copies. The host side sees a front buffer of 24 sixteen-bit words through a small register port. Each word carries the status byte of channel A in its upper half and the status byte of channel B in its lower half. The transmit side reads a separate back buffer, one bit per frame for each channel, so that the host never changes bits that are being sent.

A strobe from the transmit timebase marks the start of each status block. On that strobe the whole front buffer is copied into the back buffer in one clock, unless the host has set the inhibit control bit. The host can set inhibit while it makes a long series of updates, so that a half-written buffer is never sent. Each copy raises a sticky transfer-done flag. The host polls this flag to find the time window that is safe for its updates, and clears the flag by writing 1 to it. A mode bit selects byte-wide or word-wide host addressing. A power-down bit blocks host writes to the buffer.

Top module: `chstat_dbuf`

## Requirements
- R1: After reset, both buffers hold zero, the control register reads 0, `xfer_done` is 0, and the serializer outputs and `host_rdata` read 0.
- R2: In word mode (control bit 1 = 0), address k in 0..23 reads and writes the 16-bit word k. Upper byte bits 15:8 belong to channel A and lower byte bits 7:0 belong to channel B. `host_rdata` follows `host_addr` in the same cycle.
- R3: In byte mode (control bit 1 = 1), address n in 0..47 selects word n/2. An even n selects bits 15:8 and an odd n selects bits 7:0. Writes take `host_wdata[7:0]` and leave the other byte unchanged. Reads return the byte in bits 7:0 with bits 15:8 zero.
- R4: While the power-down bit (control bit 2) is 1, host buffer writes have no effect.
- R5: When `blk_start` is high and inhibit (control bit 0) is 0, the back buffer takes the front buffer contents at that clock edge. Host writes made before that edge change nothing on the serializer outputs.
- R6: When inhibit is 1, `blk_start` copies nothing and does not set `xfer_done`.
- R7: `xfer_done` is set at the edge of every copy and stays set until `stat_wr` is high with `stat_wdata` = 1. A write of 0 has no effect. A copy in the same cycle as a clear leaves the flag set.
- R8: For frame index i, `tx_bit_a` is bit 7-(i mod 8) of the upper byte of back word i/8, and `tx_bit_b` is the same bit of the lower byte. Each byte is sent MSB first.
- R9: `blk_start` sets the frame index to 0. `frame_adv` raises it by one, and after 191 it returns to 0.
- R10: Addresses at or above 24 in word mode, or at or above 48 in byte mode, read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 6 | Buffer address (word or byte, depending on mode) |
| host_wr | input | 1 | Buffer write strobe |
| host_wdata | input | 16 | Buffer write data |
| host_rdata | output | 16 | Buffer read data for `host_addr` |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control value: bit 2 power-down, bit 1 byte mode, bit 0 inhibit |
| ctl_rdata | output | 3 | Current control register |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Writing 1 clears `xfer_done` |
| xfer_done | output | 1 | Sticky flag: a front-to-back copy has completed |
| blk_start | input | 1 | Block boundary strobe from the transmit timebase |
| frame_adv | input | 1 | Advance to the next frame |
| tx_bit_a | output | 1 | Channel A status bit for the current frame |
| tx_bit_b | output | 1 | Channel B status bit for the current frame |

## Verification
The hardest case to reach is a clear of the transfer flag in the same cycle as a block strobe. Both the clear and the copy must land on one clock edge, with the flag already set. The bench first lets a copy set the flag. It then drives `stat_wr` and `blk_start` from the same falling edge and expects the flag to stay set. The second hard case is proving that an inhibited strobe left the back buffer alone. The front buffer is changed first. All 192 frames are then swept through the serializer outputs and compared with the contents the back buffer held before the strobe.

// File: rtl/chstat_pkg.sv
package chstat_pkg;

    // Control register layout: bit 2 power-down, bit 1 byte mode, bit 0 inhibit
    typedef struct packed {
        logic pdn;
        logic byte_mode;
        logic inhibit;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/chstat_ctl.sv
module chstat_ctl
    import chstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             stat_wr,
    input  logic             stat_wdata,
    input  logic             blk_start,
    output ctl_t             ctl,
    output logic             copy_fire,
    output logic             done_flag
);

    typedef struct packed {
        ctl_t ctl;
        logic flag;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    clr_req;

    always_comb begin
        st_d      = st_q;
        copy_fire = blk_start && !st_q.ctl.inhibit;
        clr_req   = stat_wr && stat_wdata;
        if (ctl_wr) begin
            st_d.ctl = ctl_t'(ctl_wdata);
        end
        if (copy_fire) begin
            st_d.flag = 1'b1;
        end else if (clr_req) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl       = st_q.ctl;
    assign done_flag = st_q.flag;

    // R7: a completed copy always leaves the flag set
    assert_flag_on_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        copy_fire |=> done_flag);

    // R7: a clear with no copy drops the flag
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_wdata && !copy_fire) |=> !done_flag);

    // R6: an inhibited boundary never raises a low flag
    assert_inhibit_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_start && ctl.inhibit && !done_flag) |=> !done_flag);

endmodule

// File: rtl/chstat_front.sv
module chstat_front #(
    parameter int NUM_WORDS = 24,
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = $clog2(2 * NUM_WORDS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic                                 wr,
    input  logic [WORD_W-1:0]                    wdata,
    input  logic                                 byte_mode,
    input  logic                                 pdn,
    output logic [WORD_W-1:0]                    rdata,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]     mem_out
);

    localparam int BYTE_W = WORD_W / 2;
    localparam int WIDX_W = ADDR_W - 1;

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] mem;
    } front_st_t;

    front_st_t         st_d, st_q;
    logic              hit;
    logic              upper;
    logic [WIDX_W-1:0] widx;

    // Address decode for both access modes
    always_comb begin
        if (byte_mode) begin
            hit   = (int'(addr) < 2 * NUM_WORDS);
            widx  = addr[ADDR_W-1:1];
            upper = !addr[0];
        end else begin
            hit   = (int'(addr) < NUM_WORDS);
            widx  = addr[WIDX_W-1:0];
            upper = 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr && !pdn && hit) begin
            if (!byte_mode) begin
                st_d.mem[widx] = wdata;
            end else if (upper) begin
                st_d.mem[widx][WORD_W-1:BYTE_W] = wdata[BYTE_W-1:0];
            end else begin
                st_d.mem[widx][BYTE_W-1:0] = wdata[BYTE_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            if (!byte_mode) begin
                rdata = st_q.mem[widx];
            end else if (upper) begin
                rdata[BYTE_W-1:0] = st_q.mem[widx][WORD_W-1:BYTE_W];
            end else begin
                rdata[BYTE_W-1:0] = st_q.mem[widx][BYTE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_out = st_q.mem;

    // R4: power-down freezes the host buffer
    assert_pdn_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> $stable(mem_out));

    // R10: a write outside the buffer leaves it untouched
    assert_oob_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit) |=> $stable(mem_out));

endmodule

// File: rtl/chstat_back.sv
module chstat_back #(
    parameter int NUM_WORDS = 24,
    parameter int WORD_W    = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] front_mem,
    input  logic                             copy_en,
    input  logic                             blk_start,
    input  logic                             frame_adv,
    output logic                             bit_a,
    output logic                             bit_b
);

    localparam int BYTE_W   = WORD_W / 2;
    localparam int BIT_W    = $clog2(BYTE_W);
    localparam int FRAMES   = NUM_WORDS * BYTE_W;
    localparam int IDX_W    = $clog2(FRAMES);
    localparam int WSEL_W   = IDX_W - BIT_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] mem;
        logic [IDX_W-1:0]                 idx;
    } back_st_t;

    back_st_t           st_d, st_q;
    logic [WSEL_W-1:0]  wsel;
    logic [BIT_W-1:0]   bsel;
    logic [BYTE_W-1:0]  byte_a;
    logic [BYTE_W-1:0]  byte_b;

    always_comb begin
        st_d = st_q;
        if (copy_en) begin
            st_d.mem = front_mem;
        end
        if (blk_start) begin
            st_d.idx = '0;
        end else if (frame_adv) begin
            st_d.idx = (st_q.idx == LAST_IDX) ? '0 : st_q.idx + 1'b1;
        end
    end

    // MSB first inside each byte: bit position counts down from BYTE_W-1
    always_comb begin
        wsel   = st_q.idx[IDX_W-1:BIT_W];
        bsel   = ~st_q.idx[BIT_W-1:0];
        byte_a = st_q.mem[wsel][WORD_W-1:BYTE_W];
        byte_b = st_q.mem[wsel][BYTE_W-1:0];
        bit_a  = byte_a[bsel];
        bit_b  = byte_b[bsel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a copy delivers the whole front buffer in one edge
    assert_copy_whole_R5: assert property (@(posedge clk) disable iff (!rst_n)
        copy_en |=> (st_q.mem == $past(front_mem)));

    // R6: without a copy the transmit buffer holds still
    assert_back_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_en |=> $stable(st_q.mem));

    // R9: block boundary restarts the frame count
    assert_idx_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> (st_q.idx == '0));

    // R9: frame index stays inside the block
    assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= LAST_IDX);

endmodule

// File: rtl/chstat_dbuf.sv
module chstat_dbuf
    import chstat_pkg::*;
#(
    parameter int NUM_WORDS = 24,
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = $clog2(2 * NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              stat_wr,
    input  logic              stat_wdata,
    output logic              xfer_done,
    input  logic              blk_start,
    input  logic              frame_adv,
    output logic              tx_bit_a,
    output logic              tx_bit_b
);

    ctl_t                             ctl;
    logic                             copy_fire;
    logic [NUM_WORDS-1:0][WORD_W-1:0] front_mem;

    chstat_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .blk_start  (blk_start),
        .ctl        (ctl),
        .copy_fire  (copy_fire),
        .done_flag  (xfer_done)
    );

    chstat_front #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W)
    ) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (host_addr),
        .wr        (host_wr),
        .wdata     (host_wdata),
        .byte_mode (ctl.byte_mode),
        .pdn       (ctl.pdn),
        .rdata     (host_rdata),
        .mem_out   (front_mem)
    );

    chstat_back #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W)
    ) u_back (
        .clk       (clk),
        .rst_n     (rst_n),
        .front_mem (front_mem),
        .copy_en   (copy_fire),
        .blk_start (blk_start),
        .frame_adv (frame_adv),
        .bit_a     (tx_bit_a),
        .bit_b     (tx_bit_b)
    );

    assign ctl_rdata = ctl;

    // R6: with inhibit set, a boundary produces no copy
    assert_inhibit_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_start && ctl_rdata[0]) |-> !copy_fire);

endmodule

// File: tb/chstat_dbuf_test.sv
`timescale 1ns/1ps
module chstat_dbuf_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        ctl_wr = 1'b0;
    logic [2:0]  ctl_wdata = '0;
    logic [2:0]  ctl_rdata;
    logic        stat_wr = 1'b0;
    logic        stat_wdata = 1'b0;
    logic        xfer_done;
    logic        blk_start = 1'b0;
    logic        frame_adv = 1'b0;
    logic        tx_bit_a;
    logic        tx_bit_b;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] front_m [24];
    logic [15:0] back_m  [24];

    always #10 clk = ~clk;

    chstat_dbuf uut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .xfer_done(xfer_done),
        .blk_start(blk_start), .frame_adv(frame_adv),
        .tx_bit_a(tx_bit_a), .tx_bit_b(tx_bit_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_ctl(input logic [2:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic host_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk); host_addr = a; #2; d = host_rdata;
    endtask

    task automatic pulse_blk(input logic do_copy);
        @(negedge clk); blk_start = 1'b1;
        @(negedge clk); blk_start = 1'b0;
        if (do_copy) foreach (back_m[k]) back_m[k] = front_m[k];
    endtask

    task automatic clear_flag;
        @(negedge clk); stat_wr = 1'b1; stat_wdata = 1'b1;
        @(negedge clk); stat_wr = 1'b0; stat_wdata = 1'b0;
    endtask

    // Sweep all frames from index 0 and one more to see the wrap (R8, R9)
    task automatic sweep_frames(input string req);
        for (int i = 0; i < 193; i++) begin
            int f = i % 192;
            check({req, " R8 bit A"}, 32'(tx_bit_a), 32'(back_m[f/8][15 - (f%8)]));
            check({req, " R8 bit B"}, 32'(tx_bit_b), 32'(back_m[f/8][7 - (f%8)]));
            @(negedge clk); frame_adv = 1'b1;
            @(negedge clk); frame_adv = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check("R1 ctl", 32'(ctl_rdata), 32'd0);
        check("R1 flag", 32'(xfer_done), 32'd0);
        check("R1 tx", {30'd0, tx_bit_a, tx_bit_b}, 32'd0);
        for (int a = 0; a < 24; a++) begin
            host_read(6'(a), d);
            check("R1 front", 32'(d), 32'd0);
        end
    endtask

    task automatic t_word_mode;
        logic [15:0] d;
        for (int a = 0; a < 24; a++) begin
            front_m[a] = 16'(a * 16'h0907) ^ 16'hA55A;
            host_write(6'(a), front_m[a]);
        end
        for (int a = 0; a < 24; a++) begin
            host_read(6'(a), d);
            check("R2 word readback", 32'(d), 32'(front_m[a]));
        end
    endtask

    task automatic t_byte_mode;
        logic [15:0] d;
        set_ctl(3'b010);
        check("R3 ctl", 32'(ctl_rdata), 32'd2);
        host_write(6'd5, 16'hFF3C);          // word 2 lower byte
        front_m[2][7:0] = 8'h3C;
        host_write(6'd46, 16'h00C3);         // word 23 upper byte
        front_m[23][15:8] = 8'hC3;
        host_read(6'd4, d);
        check("R3 even byte", 32'(d), 32'(front_m[2][15:8]));
        host_read(6'd5, d);
        check("R3 odd byte", 32'(d), 32'h3C);
        host_read(6'd47, d);
        check("R3 last byte", 32'(d), 32'(front_m[23][7:0]));
        host_read(6'd50, d);
        check("R10 byte oob read", 32'(d), 32'd0);
        set_ctl(3'b000);
        host_read(6'd2, d);
        check("R3 word 2 merged", 32'(d), 32'(front_m[2]));
        host_read(6'd23, d);
        check("R3 word 23 merged", 32'(d), 32'(front_m[23]));
    endtask

    task automatic t_oob;
        logic [15:0] d;
        host_write(6'd30, 16'hDEAD);
        host_read(6'd30, d);
        check("R10 word oob read", 32'(d), 32'd0);
        for (int a = 0; a < 24; a++) begin
            host_read(6'(a), d);
            check("R10 untouched", 32'(d), 32'(front_m[a]));
        end
    endtask

    task automatic t_pdn;
        logic [15:0] d;
        set_ctl(3'b100);
        host_write(6'd7, 16'h1234);
        host_read(6'd7, d);
        check("R4 write ignored", 32'(d), 32'(front_m[7]));
        set_ctl(3'b110);
        host_write(6'd14, 16'h0099);
        set_ctl(3'b000);
        host_read(6'd7, d);
        check("R4 word ignored", 32'(d), 32'(front_m[7]));
    endtask

    task automatic t_copy;
        check("R5 tx before copy", {30'd0, tx_bit_a, tx_bit_b}, 32'd0);
        check("R5 flag before copy", 32'(xfer_done), 32'd0);
        pulse_blk(1'b1);
        check("R7 flag after copy", 32'(xfer_done), 32'd1);
        sweep_frames("R5");
    endtask

    task automatic t_flag;
        @(negedge clk); stat_wr = 1'b1; stat_wdata = 1'b0;
        @(negedge clk); stat_wr = 1'b0;
        check("R7 write 0 keeps", 32'(xfer_done), 32'd1);
        clear_flag();
        check("R7 cleared", 32'(xfer_done), 32'd0);
        pulse_blk(1'b1);
        check("R7 set again", 32'(xfer_done), 32'd1);
        @(negedge clk); stat_wr = 1'b1; stat_wdata = 1'b1; blk_start = 1'b1;
        @(negedge clk); stat_wr = 1'b0; stat_wdata = 1'b0; blk_start = 1'b0;
        foreach (back_m[k]) back_m[k] = front_m[k];
        check("R7 set wins over clear", 32'(xfer_done), 32'd1);
        clear_flag();
    endtask

    task automatic t_inhibit;
        set_ctl(3'b001);
        for (int a = 0; a < 24; a++) begin
            front_m[a] = ~front_m[a] ^ 16'(a);
            host_write(6'(a), front_m[a]);
        end
        pulse_blk(1'b0);
        check("R6 no flag", 32'(xfer_done), 32'd0);
        sweep_frames("R6");
        set_ctl(3'b000);
        pulse_blk(1'b1);
        check("R6 flag after release", 32'(xfer_done), 32'd1);
        sweep_frames("R6 released");
    endtask

    task automatic t_restart;
        for (int i = 0; i < 37; i++) begin
            @(negedge clk); frame_adv = 1'b1;
        end
        @(negedge clk); frame_adv = 1'b0; blk_start = 1'b1;
        @(negedge clk); blk_start = 1'b0;
        check("R9 restart A", 32'(tx_bit_a), 32'(back_m[0][15]));
        check("R9 restart B", 32'(tx_bit_b), 32'(back_m[0][7]));
    endtask

    initial begin
        foreach (front_m[k]) begin front_m[k] = '0; back_m[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_mode();
        t_byte_mode();
        t_oob();
        t_pdn();
        t_copy();
        t_flag();
        t_inhibit();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule